// File: doc/BRIEF.md
# SCSI Interrupt Status Capture

This block gathers SCSI bus events into two byte-wide status registers and raises one interrupt request towards the host. The events are a bus reset, a parity error on received data, an unexpected disconnect, a selection time-out, a general-purpose timer expiry and a handshake-to-handshake timer expiry. Each event is held until software reads the register that holds it. That read returns the byte and clears it.

The interrupt line goes high whenever any captured bit is also enabled in its mask byte. The masks decide only whether a bit drives the interrupt. They never decide whether the bit is recorded. The block also produces the parity bit for outgoing bus data.

The bus phase logic and the timers sit outside this block and deliver single-cycle pulses to it. A disconnect is judged against the operating mode. In low-level mode every disconnect counts as unexpected. In initiator mode only a disconnect that was not expected counts.

Top module: `scsi_irq_capture`

## Requirements
- R1: Status register 0 bit 1 is set one cycle after the bus reset line or the internal assert-reset control goes active, whichever source drives it.
- R2: A reset held active for many cycles produces exactly one reset event. Once a read has cleared bit 1, it stays clear until the reset has been released and asserted again.
- R3: Status register 0 bit 0 is set when a received byte (rx_valid_i high) fails odd parity over its 8 data bits and parity bit. This happens only while par_chk_en_i is high. With the enable low, no parity error is recorded.
- R4: tx_par_o always gives odd parity over tx_data_i and tx_par_o, whatever the value of par_chk_en_i.
- R5: Status register 0 bit 2 records unexpected disconnects. In low-level mode (low_level_mode_i high) every bus_free_i pulse sets it. In initiator mode a pulse sets it only when disc_expected_i is low.
- R6: A selection time-out pulse sets status register 1 bit 2 and status register 0 bit 2 together. A general timer pulse sets register 1 bit 1, and a handshake timer pulse sets register 1 bit 0. Bits 7 to 3 of register 1 and bits 7 to 3 of register 0 always read 0.
- R7: Status bits are captured whatever the mask bytes hold.
- R8: When rd_en_i is high, rd_data_o returns the register chosen by rd_sel_i (0 selects register 0, 1 selects register 1). That register is cleared at the next clock edge, and the other register is left unchanged.
- R9: A condition that arrives in the same cycle as a clearing read of its register is kept for the following read.
- R10: irq_o is high while any status bit ANDed with its mask bit is 1, and falls once a read clears those bits.
- R11: After reset both status registers read 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Bus reset line, active high |
| rst_ctl_i | input | 1 | Internal assert-reset control bit |
| bus_free_i | input | 1 | Disconnect (bus free) pulse |
| disc_expected_i | input | 1 | Current disconnect was expected |
| low_level_mode_i | input | 1 | 1 = low-level mode, 0 = initiator mode |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received data byte |
| rx_par_i | input | 1 | Received parity bit |
| par_chk_en_i | input | 1 | Parity check enable |
| tx_data_i | input | 8 | Outgoing data byte |
| tx_par_o | output | 1 | Generated odd parity for tx_data_i |
| sel_to_i | input | 1 | Selection time-out pulse |
| gen_tmr_i | input | 1 | General timer expiry pulse |
| hth_tmr_i | input | 1 | Handshake-to-handshake timer pulse |
| mask0_i | input | 8 | Interrupt enable mask for register 0 |
| mask1_i | input | 8 | Interrupt enable mask for register 1 |
| rd_en_i | input | 1 | Read strobe (clears the selected register) |
| rd_sel_i | input | 1 | Register select for reads |
| rd_data_o | output | 8 | Read data |
| stat0_o | output | 8 | Status register 0 contents |
| stat1_o | output | 8 | Status register 1 contents |
| irq_o | output | 1 | Interrupt request |

## Verification
Disconnects are tried in both modes, with the expected flag set and clear. This shows whether the mode rule or the expected flag alone decides the outcome. Parity stimulus pairs good and bad bytes with the check enabled and disabled, which separates the gate from the check itself. A reset held over several reads, followed by a second read, shows edge detection apart from level detection. Reads that coincide with new events, and reads of one register while the other is loaded, show whether a clear is lost, leaks or drops an arriving event. Timer events under zero and non-zero masks show that the masks affect only the interrupt.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  localparam int STAT_W   = 8;
  localparam int NUM_REGS = 2;
  // register 0 layout
  localparam int S0_PAR = 0;
  localparam int S0_RST = 1;
  localparam int S0_UDC = 2;
  // register 1 layout
  localparam int S1_HTH = 0;
  localparam int S1_GEN = 1;
  localparam int S1_STO = 2;

  function automatic logic [STAT_W-1:0] valid_bits(input int idx);
    logic [STAT_W-1:0] v;
    v = '0;
    if (idx == 0) begin
      v[S0_PAR] = 1'b1; v[S0_RST] = 1'b1; v[S0_UDC] = 1'b1;
    end else begin
      v[S1_HTH] = 1'b1; v[S1_GEN] = 1'b1; v[S1_STO] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/scsi_rst_edge.sv
module scsi_rst_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q, prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/scsi_parity.sv
module scsi_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_valid_i,
  input  logic              chk_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              err_o,
  output logic              tx_par_o
);
  // odd parity: total number of ones including the parity bit is odd
  always_comb begin
    err_o    = rx_valid_i & chk_en_i & ~(^{rx_data_i, rx_par_i});
    tx_par_o = ~(^tx_data_i);
  end
endmodule

// File: rtl/scsi_rtc_reg.sv
module scsi_rtc_reg #(
  parameter int              W     = 8,
  parameter logic [W-1:0]    VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;

  // a set in the clearing cycle wins over the clear
  always_comb begin
    q_nxt = clr_i ? '0 : q_r;
    q_nxt = (q_nxt | set_i) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/scsi_irq_capture.sv
module scsi_irq_capture
  import scsi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_i,
  input  logic              rst_ctl_i,
  input  logic              bus_free_i,
  input  logic              disc_expected_i,
  input  logic              low_level_mode_i,
  input  logic              rx_valid_i,
  input  logic [STAT_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              par_chk_en_i,
  input  logic [STAT_W-1:0] tx_data_i,
  output logic              tx_par_o,
  input  logic              sel_to_i,
  input  logic              gen_tmr_i,
  input  logic              hth_tmr_i,
  input  logic [STAT_W-1:0] mask0_i,
  input  logic [STAT_W-1:0] mask1_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] stat0_o,
  output logic [STAT_W-1:0] stat1_o,
  output logic              irq_o
);
  logic rst_rise, par_err, udc_evt;
  logic [NUM_REGS-1:0][STAT_W-1:0] set_v, q_v, mask_v;
  logic [NUM_REGS-1:0]             clr_v;

  scsi_rst_edge u_rst_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (bus_rst_i | rst_ctl_i),
    .rise_o (rst_rise)
  );

  scsi_parity #(.DATA_W(STAT_W)) u_par (
    .rx_data_i  (rx_data_i),
    .rx_par_i   (rx_par_i),
    .rx_valid_i (rx_valid_i),
    .chk_en_i   (par_chk_en_i),
    .tx_data_i  (tx_data_i),
    .err_o      (par_err),
    .tx_par_o   (tx_par_o)
  );

  // disconnect classification by mode; a selection time-out also counts
  always_comb begin
    udc_evt = (bus_free_i & (low_level_mode_i | ~disc_expected_i)) | sel_to_i;
  end

  always_comb begin
    set_v = '0;
    set_v[0][S0_PAR] = par_err;
    set_v[0][S0_RST] = rst_rise;
    set_v[0][S0_UDC] = udc_evt;
    set_v[1][S1_HTH] = hth_tmr_i;
    set_v[1][S1_GEN] = gen_tmr_i;
    set_v[1][S1_STO] = sel_to_i;
    mask_v[0] = mask0_i;
    mask_v[1] = mask1_i;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stat
    assign clr_v[g] = rd_en_i & (int'(rd_sel_i) == g);
    scsi_rtc_reg #(.W(STAT_W), .VALID(valid_bits(g))) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (q_v[g])
    );
  end

  always_comb begin
    irq_o = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) irq_o = irq_o | (|(q_v[i] & mask_v[i]));
  end

  assign rd_data_o = q_v[rd_sel_i];
  assign stat0_o   = q_v[0];
  assign stat1_o   = q_v[1];
endmodule

// File: rtl/scsi_irq_capture_chk.sv
module scsi_irq_capture_chk
  import scsi_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst_i,
  input logic              rst_ctl_i,
  input logic              bus_free_i,
  input logic              disc_expected_i,
  input logic              low_level_mode_i,
  input logic              par_chk_en_i,
  input logic [STAT_W-1:0] tx_data_i,
  input logic              tx_par_o,
  input logic              sel_to_i,
  input logic              rd_en_i,
  input logic              rd_sel_i,
  input logic [STAT_W-1:0] mask1_i,
  input logic [STAT_W-1:0] stat0_o,
  input logic [STAT_W-1:0] stat1_o,
  input logic              irq_o
);
  a_r1_rst_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_i | rst_ctl_i) |=> stat0_o[S0_RST]);

  a_r3_par_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_chk_en_i && !stat0_o[S0_PAR]) |=> !stat0_o[S0_PAR]);

  a_r4_tx_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (^{tx_data_i, tx_par_o}) == 1'b1);

  a_r5_low_level: assert property (@(posedge clk) disable iff (!rst_n)
    (low_level_mode_i && bus_free_i) |=> stat0_o[S0_UDC]);

  a_r5_expected: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_level_mode_i && bus_free_i && disc_expected_i && !sel_to_i &&
     !stat0_o[S0_UDC]) |=> !stat0_o[S0_UDC]);

  a_r6_sto_both: assert property (@(posedge clk) disable iff (!rst_n)
    sel_to_i |=> (stat1_o[S1_STO] && stat0_o[S0_UDC]));

  a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0_o[7:3] == '0) && (stat1_o[7:3] == '0));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_sel_i && !sel_to_i) |=> stat1_o[S1_STO] == 1'b0);

  a_r9_keep_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_to_i && rd_en_i) |=> stat1_o[S1_STO]);

  a_r10_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat1_o & mask1_i) != '0) |-> irq_o);
endmodule

bind scsi_irq_capture scsi_irq_capture_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_rst_i        (bus_rst_i),
  .rst_ctl_i        (rst_ctl_i),
  .bus_free_i       (bus_free_i),
  .disc_expected_i  (disc_expected_i),
  .low_level_mode_i (low_level_mode_i),
  .par_chk_en_i     (par_chk_en_i),
  .tx_data_i        (tx_data_i),
  .tx_par_o         (tx_par_o),
  .sel_to_i         (sel_to_i),
  .rd_en_i          (rd_en_i),
  .rd_sel_i         (rd_sel_i),
  .mask1_i          (mask1_i),
  .stat0_o          (stat0_o),
  .stat1_o          (stat1_o),
  .irq_o            (irq_o)
);

// File: tb/sim_scsi_irq_capture.sv
`timescale 1ns/1ps
module sim_scsi_irq_capture;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_rst_i, rst_ctl_i, bus_free_i, disc_expected_i, low_level_mode_i;
  logic rx_valid_i, rx_par_i, par_chk_en_i, sel_to_i, gen_tmr_i, hth_tmr_i;
  logic rd_en_i, rd_sel_i, tx_par_o, irq_o;
  logic [7:0] rx_data_i, tx_data_i, mask0_i, mask1_i, rd_data_o, stat0_o, stat1_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  scsi_irq_capture u0 (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  // driver: queue the expected value, then strobe a read
  task automatic do_read(input logic sel, input logic [7:0] exp, input string tag);
    step;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en_i = 1'b1; rd_sel_i = sel;
  endtask

  task automatic end_read;
    step;
    rd_en_i = 1'b0;
  endtask

  // monitor: compare read data mid-cycle
  always @(negedge clk) begin
    if (rst_n && rd_en_i) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read, actual %02h expected none", rd_data_o);
      end else begin
        check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {bus_rst_i, rst_ctl_i, bus_free_i, disc_expected_i, low_level_mode_i} = '0;
    {rx_valid_i, rx_par_i, par_chk_en_i, sel_to_i, gen_tmr_i, hth_tmr_i} = '0;
    rd_en_i = 1'b0; rd_sel_i = 1'b0;
    rx_data_i = '0; tx_data_i = '0; mask0_i = '0; mask1_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step;
    @(negedge clk);
    check("R11 stat0", stat0_o, 8'h00);
    check("R11 stat1", stat1_o, 8'h00);
    check("R11 irq", {7'b0, irq_o}, 8'h00);

    // R4 parity generation, enable both ways
    for (int i = 0; i < 6; i++) begin
      step;
      tx_data_i = 8'(i * 37 + 3);
      par_chk_en_i = i[0];
      @(negedge clk);
      check("R4 tx parity odd", {7'b0, ^{tx_data_i, tx_par_o}}, 8'h01);
    end
    par_chk_en_i = 1'b0;

    // R1 both reset sources
    step; bus_rst_i = 1'b1; step; bus_rst_i = 1'b0;
    do_read(1'b0, 8'h02, "R1 external reset"); end_read;
    step; rst_ctl_i = 1'b1; step; rst_ctl_i = 1'b0;
    do_read(1'b0, 8'h02, "R1 internal reset"); end_read;

    // R2 held reset: one event only
    step; bus_rst_i = 1'b1;
    repeat (3) step;
    do_read(1'b0, 8'h02, "R2 held reset first read"); end_read;
    repeat (2) step;
    do_read(1'b0, 8'h00, "R2 held reset no re-trigger"); end_read;
    bus_rst_i = 1'b0;

    // R3 parity checking
    step; rx_valid_i = 1'b1; rx_data_i = 8'h01; rx_par_i = 1'b1; // bad
    step; rx_valid_i = 1'b0;
    do_read(1'b0, 8'h00, "R3 bad parity ignored when disabled"); end_read;
    par_chk_en_i = 1'b1;
    step; rx_valid_i = 1'b1; rx_data_i = 8'h03; rx_par_i = 1'b1; // good
    step; rx_valid_i = 1'b0;
    do_read(1'b0, 8'h00, "R3 good parity"); end_read;
    step; rx_valid_i = 1'b1; rx_data_i = 8'hA5; rx_par_i = 1'b0; // bad
    step; rx_valid_i = 1'b0;
    do_read(1'b0, 8'h01, "R3 bad parity detected"); end_read;
    par_chk_en_i = 1'b0;

    // R5 disconnect classification
    low_level_mode_i = 1'b1; disc_expected_i = 1'b1;
    step; bus_free_i = 1'b1; step; bus_free_i = 1'b0;
    do_read(1'b0, 8'h04, "R5 low-level expected disconnect"); end_read;
    low_level_mode_i = 1'b0;
    step; bus_free_i = 1'b1; step; bus_free_i = 1'b0;
    do_read(1'b0, 8'h00, "R5 initiator expected disconnect"); end_read;
    disc_expected_i = 1'b0;
    step; bus_free_i = 1'b1; step; bus_free_i = 1'b0;
    do_read(1'b0, 8'h04, "R5 initiator unexpected disconnect"); end_read;

    // R6 timers and time-out; R8 read leaves other register intact
    step; sel_to_i = 1'b1; step; sel_to_i = 1'b0;
    do_read(1'b1, 8'h04, "R6 selection time-out reg1"); end_read;
    do_read(1'b0, 8'h04, "R8 reg0 untouched by reg1 read"); end_read;
    step; gen_tmr_i = 1'b1; step; gen_tmr_i = 1'b0;
    do_read(1'b1, 8'h02, "R6 general timer"); end_read;
    step; hth_tmr_i = 1'b1; step; hth_tmr_i = 1'b0;
    do_read(1'b1, 8'h01, "R6 handshake timer"); end_read;
    do_read(1'b1, 8'h00, "R8 cleared after read"); end_read;

    // R7 / R10 masks
    step; gen_tmr_i = 1'b1; step; gen_tmr_i = 1'b0;
    @(negedge clk); check("R10 irq low with zero mask", {7'b0, irq_o}, 8'h00);
    do_read(1'b1, 8'h02, "R7 captured with zero mask"); end_read;
    mask1_i = 8'h02;
    step; gen_tmr_i = 1'b1; step; gen_tmr_i = 1'b0;
    @(negedge clk); check("R10 irq high when enabled", {7'b0, irq_o}, 8'h01);
    do_read(1'b1, 8'h02, "R10 read enabled bit"); end_read;
    @(negedge clk); check("R10 irq drops after read", {7'b0, irq_o}, 8'h00);
    mask1_i = 8'h00; mask0_i = 8'h04;
    disc_expected_i = 1'b0;
    step; bus_free_i = 1'b1; step; bus_free_i = 1'b0;
    @(negedge clk); check("R10 irq from reg0", {7'b0, irq_o}, 8'h01);
    do_read(1'b0, 8'h04, "R10 reg0 read"); end_read;
    mask0_i = 8'h00;

    // R9 event coinciding with clearing read
    step; gen_tmr_i = 1'b1; step; gen_tmr_i = 1'b0;
    do_read(1'b1, 8'h02, "R9 read while event arrives"); hth_tmr_i = 1'b1;
    end_read; hth_tmr_i = 1'b0;
    do_read(1'b1, 8'h01, "R9 coinciding event kept"); end_read;

    repeat (3) step;
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule